// File: doc/BRIEF.md
# Bit-Serial Lane Array

This block is a row of one-bit processing lanes, one lane per data bit of an on-chip RAM word. Every lane runs the same operation in the same cycle. Each lane has a one-bit ALU, its own carry flip-flop and a small private bit stack. A sequencer issues a four-bit operation code together with a RAM row address. The RAM row named by that address is read in the same cycle, and the array consumes the read word one cycle later. Results leave through a write-back word, an address and a write enable.

Arithmetic wider than one bit is done by iterating over bit positions, least significant first. A W-bit add therefore costs W passes of push, push, add, pop. The carry of each lane stays in that lane's flip-flop from one bit position to the next. All lanes share one stack pointer, because they all execute the same stream. The stack wraps silently when it overflows or underflows.

Top module: `bsl_array`

## Requirements
- R1: While reset is held and after it is released, `wr_en` is low until a pop executes. Every lane's carry and every stack entry reset to 0, so a pop with nothing pushed writes an all-zero word.
- R2: Opcode 1 (push) issued with address A in cycle t pushes the RAM word of row A, which arrives on `rd_data` in cycle t+1, onto every lane's stack at the end of cycle t+1.
- R3: Opcode 2 (pop), issued in cycle t with address A, raises `wr_en` during cycle t+1 with `wr_addr` = A and `wr_data` = the stack top, then removes the top.
- R4: Opcodes 3, 4 and 5 (AND, OR, XOR) pop the top two bits of each lane and push their bitwise AND, OR or XOR.
- R5: Opcode 6 (add with carry) pops two bits a and b in each lane and pushes a^b^c, where c is that lane's carry. The carry becomes the majority of a, b and c.
- R6: Opcode 7 (NOT) inverts the stack top of each lane in place.
- R7: Opcode 8 clears the carry of every lane and opcode 9 sets it.
- R8: The carry of a lane keeps its value under every opcode except 6, 8 and 9.
- R9: Opcode 0 and opcodes 10 to 15 change neither the stacks, the carries nor the outputs.
- R10: The stack holds 4 entries per lane. A fifth push overwrites the oldest entry, and further pops keep cycling through the 4 slots with no error.
- R11: A clear-carry followed by 16 passes of push, push, add, pop, least significant bit first, yields in every lane the 16-bit sum of that lane's operands. A final add of two zero rows then yields the carry out.
- R12: `wr_en` is raised exactly once per executed pop and at no other time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_code | input | 4 | Operation issued by the sequencer |
| op_addr | input | ADDR_W | RAM row that goes with the operation |
| rd_data | input | LANES | RAM read word, one cycle after its address |
| wr_en | output | 1 | Write strobe for the RAM |
| wr_addr | output | ADDR_W | Row to write |
| wr_data | output | LANES | Stack top of every lane |

## Verification
The bench feeds operand rows whose lanes mix every pairing of 0 and 1, so a swapped logic function or a misrouted stack operand corrupts some lanes. It reads the carry back through an add of two zero rows after each operation. An ALU that disturbed the carry on a non-add opcode, or a clear/set that missed some lanes, would leave the wrong bits in that probe row. A fifth push followed by five pops shows whether the stack wraps, and a pop right after reset shows whether it comes back zeroed. A 16-bit ripple add includes a lane that carries through all sixteen bits, which exposes a lost or stale carry between bit positions. The reserved opcodes and a count of write strobes expose any stray stack change or spurious write.

// File: rtl/bsl_pkg.sv
package bsl_pkg;

   typedef enum logic [3:0] {
      OPC_IDLE  = 4'd0,
      OPC_LOAD  = 4'd1,
      OPC_STORE = 4'd2,
      OPC_AND   = 4'd3,
      OPC_OR    = 4'd4,
      OPC_XOR   = 4'd5,
      OPC_ADDC  = 4'd6,
      OPC_INV   = 4'd7,
      OPC_CCLR  = 4'd8,
      OPC_CSET  = 4'd9
   } bsl_opc_e;

   typedef enum logic [1:0] {
      FN_AND  = 2'd0,
      FN_OR   = 2'd1,
      FN_XOR  = 2'd2,
      FN_ADDC = 2'd3
   } bsl_fn_e;

   typedef struct packed {
      logic    load;
      logic    store;
      logic    dyad;
      logic    monad;
      logic    addc;
      logic    cclr;
      logic    cset;
      bsl_fn_e fn;
   } bsl_ctl_t;

   function automatic bsl_ctl_t bsl_decode(input logic [3:0] code);
      bsl_ctl_t c;
      c = '0;
      c.fn = FN_AND;
      case (code)
         OPC_LOAD:  c.load = 1'b1;
         OPC_STORE: c.store = 1'b1;
         OPC_AND:   begin c.dyad = 1'b1; c.fn = FN_AND; end
         OPC_OR:    begin c.dyad = 1'b1; c.fn = FN_OR; end
         OPC_XOR:   begin c.dyad = 1'b1; c.fn = FN_XOR; end
         OPC_ADDC:  begin c.dyad = 1'b1; c.fn = FN_ADDC; c.addc = 1'b1; end
         OPC_INV:   c.monad = 1'b1;
         OPC_CCLR:  c.cclr = 1'b1;
         OPC_CSET:  c.cset = 1'b1;
         default:   c = c;
      endcase
      return c;
   endfunction

endpackage

// File: rtl/bsl_issue.sv
module bsl_issue #(
   parameter int ADDR_W = 10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [3:0]        op_code,
   input  logic [ADDR_W-1:0] op_addr,
   output bsl_pkg::bsl_ctl_t ctl,
   output logic [ADDR_W-1:0] addr_q
);
   import bsl_pkg::*;

   logic [3:0] code_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         code_q <= OPC_IDLE;
         addr_q <= '0;
      end else begin
         code_q <= op_code;
         addr_q <= op_addr;
      end
   end

   always_comb ctl = bsl_decode(code_q);

   // R2: the operation executes one cycle behind its issue, in step with the RAM
   assert_issue_delay_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |-> (code_q == $past(op_code) && addr_q == $past(op_addr)));

   // decoded controls are mutually exclusive classes
   assert_ctl_exclusive_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({ctl.load, ctl.store, ctl.dyad, ctl.monad, ctl.cclr, ctl.cset}));

endmodule

// File: rtl/bsl_lane.sv
module bsl_lane (
   input  logic              clk,
   input  logic              rst_n,
   input  bsl_pkg::bsl_ctl_t ctl,
   input  logic              top_bit,
   input  logic              sec_bit,
   output logic              res_bit,
   output logic              carry_q
);
   import bsl_pkg::*;

   logic carry_nx;

   always_comb begin
      if (ctl.monad) begin
         res_bit = ~top_bit;
      end else begin
         case (ctl.fn)
            FN_AND:  res_bit = top_bit & sec_bit;
            FN_OR:   res_bit = top_bit | sec_bit;
            FN_XOR:  res_bit = top_bit ^ sec_bit;
            default: res_bit = top_bit ^ sec_bit ^ carry_q;
         endcase
      end
   end

   always_comb begin
      carry_nx = carry_q;
      if (ctl.cclr)
         carry_nx = 1'b0;
      else if (ctl.cset)
         carry_nx = 1'b1;
      else if (ctl.addc)
         carry_nx = (top_bit & sec_bit) | (carry_q & (top_bit ^ sec_bit));
   end

   always_ff @(posedge clk) begin
      if (!rst_n) carry_q <= 1'b0;
      else        carry_q <= carry_nx;
   end

   assert_carry_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !(ctl.addc || ctl.cclr || ctl.cset) |=> $stable(carry_q));

   assert_carry_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
      ctl.cclr |=> !carry_q);

   assert_carry_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
      ctl.cset |=> carry_q);

endmodule

// File: rtl/bsl_stack.sv
module bsl_stack #(
   parameter int LANES = 36,
   parameter int DEPTH = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  bsl_pkg::bsl_ctl_t ctl,
   input  logic [LANES-1:0]  load_data,
   input  logic [LANES-1:0]  res_data,
   output logic [LANES-1:0]  top,
   output logic [LANES-1:0]  second
);
   localparam int SP_W = $clog2(DEPTH);

   generate
      if (DEPTH < 2 || (1 << SP_W) != DEPTH) begin : g_bad_depth
         $error("bsl_stack: DEPTH must be a power of two of at least 2");
      end
   endgenerate

   logic [SP_W-1:0]  sp;
   logic [SP_W-1:0]  sp_up;
   logic [SP_W-1:0]  sp_dn;
   logic [LANES-1:0] slot [DEPTH];

   assign sp_up = sp + 1'b1;
   assign sp_dn = sp - 1'b1;

   always_ff @(posedge clk) begin
      if (!rst_n)
         sp <= SP_W'(DEPTH - 1);
      else if (ctl.load)
         sp <= sp_up;
      else if (ctl.store || ctl.dyad)
         sp <= sp_dn;
   end

   generate
      for (genvar e = 0; e < DEPTH; e++) begin : g_slot
         logic [LANES-1:0] q;
         always_ff @(posedge clk) begin
            if (!rst_n)
               q <= '0;
            else if (ctl.load && sp_up == SP_W'(e))
               q <= load_data;
            else if (ctl.dyad && sp_dn == SP_W'(e))
               q <= res_data;
            else if (ctl.monad && sp == SP_W'(e))
               q <= res_data;
         end
         assign slot[e] = q;
      end
   endgenerate

   assign top    = slot[sp];
   assign second = slot[sp_dn];

   assert_load_top_R2: assert property (@(posedge clk) disable iff (!rst_n)
      ctl.load |=> top == $past(load_data));

   assert_store_pops_R3: assert property (@(posedge clk) disable iff (!rst_n)
      ctl.store |=> top == $past(second));

   assert_dyad_result_R4: assert property (@(posedge clk) disable iff (!rst_n)
      ctl.dyad |=> top == $past(res_data));

endmodule

// File: rtl/bsl_array.sv
module bsl_array #(
   parameter int LANES  = 36,
   parameter int ADDR_W = 10,
   parameter int DEPTH  = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [3:0]        op_code,
   input  logic [ADDR_W-1:0] op_addr,
   input  logic [LANES-1:0]  rd_data,
   output logic              wr_en,
   output logic [ADDR_W-1:0] wr_addr,
   output logic [LANES-1:0]  wr_data
);
   import bsl_pkg::*;

   generate
      if (LANES < 1 || ADDR_W < 1) begin : g_bad_size
         $error("bsl_array: LANES and ADDR_W must be positive");
      end
   endgenerate

   bsl_ctl_t         ctl;
   logic [ADDR_W-1:0] addr_q;
   logic [LANES-1:0] top;
   logic [LANES-1:0] second;
   logic [LANES-1:0] res;
   logic [LANES-1:0] carry;

   bsl_issue #(.ADDR_W(ADDR_W)) issue_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .op_code (op_code),
      .op_addr (op_addr),
      .ctl     (ctl),
      .addr_q  (addr_q)
   );

   bsl_stack #(.LANES(LANES), .DEPTH(DEPTH)) stack_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .ctl       (ctl),
      .load_data (rd_data),
      .res_data  (res),
      .top       (top),
      .second    (second)
   );

   generate
      for (genvar l = 0; l < LANES; l++) begin : g_lane
         bsl_lane lane_i (
            .clk     (clk),
            .rst_n   (rst_n),
            .ctl     (ctl),
            .top_bit (top[l]),
            .sec_bit (second[l]),
            .res_bit (res[l]),
            .carry_q (carry[l])
         );
      end
   endgenerate

   assign wr_en   = ctl.store;
   assign wr_addr = addr_q;
   assign wr_data = top;

   assert_write_only_store_R12: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> $past(op_code) == OPC_STORE);

   assert_write_addr_R3: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> wr_addr == $past(op_addr));

   assert_lanes_carry_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
      ctl.cclr |=> carry == '0);

endmodule

// File: tb/bsl_array_tb.sv
`timescale 1ns/100ps
module bsl_array_tb_top;
   localparam int LANES  = 36;
   localparam int ADDR_W = 10;
   localparam int NV     = 10;
   localparam int ZROW   = 100;

   localparam logic [3:0] V_OP [NV] = '{4'd3, 4'd4, 4'd5, 4'd6, 4'd6, 4'd7, 4'd0, 4'd12, 4'd15, 4'd6};
   localparam logic [35:0] V_A [NV] = '{36'hC_A5F0_3C96, 36'h3_0F0F_55AA, 36'hF_FF00_A5A5,
                                        36'h9_1234_ABCD, 36'hE_5A5A_0FF0, 36'h0_0000_0000,
                                        36'h7_7777_8888, 36'hA_BCDE_F012, 36'h1_1111_2222,
                                        36'hF_FFFF_FFFF};
   localparam logic [35:0] V_B [NV] = '{36'hA_33CC_F00F, 36'h5_F0F0_3355, 36'h0_FF0F_5AA5,
                                        36'h6_FEDC_5432, 36'hB_C3C3_9669, 36'h4_9ABC_0F0F,
                                        36'h2_4680_1357, 36'h5_5555_AAAA, 36'hD_EAD0_BEEF,
                                        36'h0_0000_0001};
   localparam logic V_C [NV] = '{1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1};

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic [3:0]        op_code = 4'd0;
   logic [ADDR_W-1:0] op_addr = '0;
   logic [LANES-1:0]  rd_data;
   logic              wr_en;
   logic [ADDR_W-1:0] wr_addr;
   logic [LANES-1:0]  wr_data;

   logic              host_we = 1'b0;
   logic [ADDR_W-1:0] host_addr = '0;
   logic [LANES-1:0]  host_data = '0;
   logic [LANES-1:0]  mem [1 << ADDR_W];

   int total = 0;
   int fails = 0;
   int pops = 0;
   int writes = 0;

   always #2.5 clk = ~clk;

   bsl_array #(.LANES(LANES), .ADDR_W(ADDR_W), .DEPTH(4)) dut_i (
      .clk(clk), .rst_n(rst_n), .op_code(op_code), .op_addr(op_addr),
      .rd_data(rd_data), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data)
   );

   // read-first synchronous RAM wrapper
   initial for (int i = 0; i < (1 << ADDR_W); i++) mem[i] = '0;
   always @(posedge clk) begin
      rd_data <= mem[op_addr];
      if (host_we) mem[host_addr] <= host_data;
      else if (wr_en) mem[wr_addr] <= wr_data;
      if (rst_n && wr_en) writes <= writes + 1;
   end

   task automatic chk(input string req, input logic [35:0] act, input logic [35:0] exp);
      total++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic issue(input logic [3:0] op, input int addr);
      @(negedge clk);
      op_code = op;
      op_addr = ADDR_W'(addr);
      if (op == 4'd2) pops++;
   endtask

   task automatic settle();
      issue(4'd0, 0);
      issue(4'd0, 0);
      @(negedge clk);
   endtask

   task automatic host_write(input int addr, input logic [35:0] d);
      @(negedge clk);
      host_we = 1'b1; host_addr = ADDR_W'(addr); host_data = d;
      @(negedge clk);
      host_we = 1'b0;
   endtask

   task automatic carry_probe(input int dst);
      issue(4'd1, ZROW);
      issue(4'd1, ZROW);
      issue(4'd6, 0);
      issue(4'd2, dst);
      settle();
   endtask

   function automatic logic [35:0] ref_res(input logic [3:0] op, input logic [35:0] a,
                                           input logic [35:0] b, input logic c);
      case (op)
         4'd3: return a & b;
         4'd4: return a | b;
         4'd5: return a ^ b;
         4'd6: return a ^ b ^ {36{c}};
         4'd7: return ~b;
         default: return b;
      endcase
   endfunction

   function automatic logic [35:0] ref_carry(input logic [3:0] op, input logic [35:0] a,
                                             input logic [35:0] b, input logic c);
      if (op == 4'd6) return (a & b) | ({36{c}} & (a ^ b));
      return {36{c}};
   endfunction

   function automatic logic [15:0] opa(input int l);
      if (l == 0) return 16'hFFFF;
      return 16'(l * 2731 + 17);
   endfunction

   function automatic logic [15:0] opb(input int l);
      if (l == 0) return 16'h0001;
      return ~16'(l * 977);
   endfunction

   initial begin
      repeat (200000) @(posedge clk);
      total++; fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
   end

   initial begin
      // R1: reset state
      repeat (3) @(negedge clk);
      chk("R1 wr_en in reset", 36'(wr_en), 36'd0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 wr_en after reset", 36'(wr_en), 36'd0);
      issue(4'd2, 5);
      settle();
      chk("R1 stack zero after reset", mem[5], 36'd0);
      carry_probe(6);
      chk("R1 carry zero after reset", mem[6], 36'd0);

      // table of vectors: R4 R5 R6 R7 R8 R9
      for (int v = 0; v < NV; v++) begin
         host_write(0, V_A[v]);
         host_write(1, V_B[v]);
         issue(V_C[v] ? 4'd9 : 4'd8, 0);
         issue(4'd1, 0);
         issue(4'd1, 1);
         issue(V_OP[v], 0);
         issue(4'd2, 2);
         settle();
         chk($sformatf("R4 R5 R6 R9 result op=%0d", V_OP[v]), mem[2],
             ref_res(V_OP[v], V_A[v], V_B[v], V_C[v]));
         carry_probe(3);
         chk($sformatf("R5 R7 R8 carry op=%0d", V_OP[v]), mem[3],
             ref_carry(V_OP[v], V_A[v], V_B[v], V_C[v]));
      end

      // R3: write timing and address
      host_write(20, 36'h5_A5A5_A5A5);
      issue(4'd1, 20);
      issue(4'd2, 21);
      issue(4'd0, 0);
      chk("R3 wr_en one cycle after pop", 36'(wr_en), 36'd1);
      chk("R3 wr_addr", 36'(wr_addr), 36'd21);
      chk("R3 wr_data", wr_data, 36'h5_A5A5_A5A5);
      @(negedge clk);
      chk("R3 wr_en falls", 36'(wr_en), 36'd0);

      // R10: five pushes, five pops
      for (int i = 0; i < 5; i++) host_write(200 + i, 36'h1_0000_0000 * (i + 1) + 36'(i * 7 + 3));
      for (int i = 0; i < 5; i++) issue(4'd1, 200 + i);
      for (int i = 0; i < 5; i++) issue(4'd2, 210 + i);
      settle();
      chk("R10 pop 1 newest", mem[210], mem[204]);
      chk("R10 pop 2", mem[211], mem[203]);
      chk("R10 pop 3", mem[212], mem[202]);
      chk("R10 pop 4", mem[213], mem[201]);
      chk("R10 pop 5 wraps to newest", mem[214], mem[204]);

      // R11: 16-bit add across all lanes
      for (int i = 0; i < 16; i++) begin
         logic [35:0] ra, rb;
         for (int l = 0; l < LANES; l++) begin
            logic [15:0] av, bv;
            av = opa(l); bv = opb(l);
            ra[l] = av[i]; rb[l] = bv[i];
         end
         host_write(300 + i, ra);
         host_write(320 + i, rb);
      end
      issue(4'd8, 0);
      for (int i = 0; i < 16; i++) begin
         issue(4'd1, 300 + i);
         issue(4'd1, 320 + i);
         issue(4'd6, 0);
         issue(4'd2, 340 + i);
      end
      settle();
      carry_probe(356);
      for (int i = 0; i < 17; i++) begin
         logic [35:0] ex;
         for (int l = 0; l < LANES; l++) begin
            logic [16:0] s;
            s = {1'b0, opa(l)} + {1'b0, opb(l)};
            ex[l] = s[i];
         end
         chk($sformatf("R11 sum bit %0d", i), mem[340 + i], ex);
      end

      // R12: strobes match pops
      @(negedge clk);
      chk("R12 write strobe count", 36'(writes), 36'(pops));

      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
   end
endmodule